// File: doc/BRIEF.md
# Link Error Monitor

The block sits on the receive side of one point-to-point physical connection. Every cycle it may accept a 5-bit line code group, marked by a valid strobe. It sorts each group into legal or violation. The group then goes to the repeat path. A violation is replaced by the halt group before it leaves, so the next link never sees the same fault, and each error event is counted only at the port where it first showed up. Every group counts, whatever traffic it belongs to: data, delimiters, idle fill, or frames that are being stripped.

Errors are tallied over a window of 2^WIN_LOG2 accepted groups. Only a fraction of line errors show up as code violations, so the block reports the decimal exponent of the estimated error rate and no finer figure. When a window closes, the block records three things: the window's violation count, the exponent, and a one-cycle completion pulse. If the exponent falls below a programmable cutoff, meaning the link is worse than allowed, a sticky removal request is raised. That request stays up until it is explicitly cleared. A second threshold drives a level alarm.

Top module: `link_err_mon`

## Requirements
- R1: A code group is a violation exactly when it is one of 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000. All other 24 values are legal, including 00000 (quiet) and 00100 (halt).
- R2: One cycle after the input, rpt_valid equals cg_valid. When rpt_valid is set, rpt_data equals the input group, or 00100 if that group was a violation.
- R3: A window is 2^WIN_LOG2 groups with cg_valid high. Cycles with cg_valid low are neither counted nor checked for violations. In the cycle after the last group of a window is accepted, win_done is high for one cycle and err_count holds that window's violation count. err_count is stable at all other times.
- R4: At a window end, ber_exp becomes floor(WIN_LOG2*log10(2)) - floor(log10(count)), or 15 when the count is 0. With WIN_LOG2=10 this gives: 1..9 gives 3, 10..99 gives 2, 100..999 gives 1, 1000..1024 gives 0.
- R5: fault_req is set at a window end whose new ber_exp is below cutoff_exp. Once set, it stays set.
- R6: fault_clr clears fault_req on the next edge. If a window end sets the fault in the same cycle, the set wins.
- R7: alarm is high exactly while ber_exp < alarm_exp.
- R8: win_restart discards the partial window: its count, its position, and the group presented in the same cycle, which is still repeated.
- R9: After reset, err_count=0, ber_exp=15, fault_req=0, win_done=0, rpt_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_valid | input | 1 | Code group present this cycle |
| cg_data | input | 5 | Received code group |
| win_restart | input | 1 | Abandon the current window and start a new one |
| cutoff_exp | input | 4 | Exponent below which removal is requested |
| alarm_exp | input | 4 | Exponent below which the alarm is raised |
| fault_clr | input | 1 | Clear the removal request |
| rpt_valid | output | 1 | Repeat-side group present |
| rpt_data | output | 5 | Repeat-side group with violations replaced |
| err_count | output | WIN_LOG2+1 | Violation count of the last finished window |
| ber_exp | output | 4 | Error-rate exponent of the last finished window |
| win_done | output | 1 | One-cycle pulse at a window end |
| alarm | output | 1 | Exponent below alarm threshold |
| fault_req | output | 1 | Sticky link-removal request |

## Verification
The hardest case to reach is a window that ends with a count exactly on a decade edge (9/10, 99/100, 999/1000) or with every group in error. The stimulus reaches these by placing corrupted groups at the start of a window and padding the rest with legal groups. Each corrupted group is made by complementing an adjacent bit pair of a data group, so that it lands in the violation set. A second hard case is a clear that coincides with a fault-setting window end. The bench lines up fault_clr with the last accepted group of a window to reach it.

// File: rtl/lem_pkg.sv
package lem_pkg;
    localparam int          CG_W     = 5;
    localparam int          EXP_W    = 4;
    localparam logic [4:0]  HALT_CG  = 5'b00100;
    localparam logic [3:0]  EXP_NONE = 4'd15;
endpackage

// File: rtl/lem_code_check.sv
module lem_code_check
    import lem_pkg::*;
(
    input  logic [CG_W-1:0] cg_in,
    output logic            viol,
    output logic [CG_W-1:0] cg_fix
);
    always_comb begin
        case (cg_in)
            5'b00001, 5'b00010, 5'b00011, 5'b00101,
            5'b00110, 5'b01000, 5'b01100, 5'b10000: viol = 1'b1;
            default:                                viol = 1'b0;
        endcase
        cg_fix = viol ? HALT_CG : cg_in;
    end
endmodule

// File: rtl/lem_ber_calc.sv
module lem_ber_calc
    import lem_pkg::*;
#(
    parameter int WIN_LOG2 = 10,
    parameter int CNT_W    = WIN_LOG2 + 1
) (
    input  logic [CNT_W-1:0] count,
    output logic [EXP_W-1:0] exp_o
);
    localparam int WIN_DEC = (WIN_LOG2 * 30103) / 100000;

    always_comb begin
        int    lg;
        longint pw;
        lg = 0;
        pw = 10;
        for (int k = 0; k < 10; k++) begin
            if (longint'(count) >= pw) lg = lg + 1;
            pw = pw * 10;
        end
        if (count == '0) exp_o = EXP_NONE;
        else             exp_o = EXP_W'(WIN_DEC - lg);
    end
endmodule

// File: rtl/link_err_mon.sv
module link_err_mon
    import lem_pkg::*;
#(
    parameter int WIN_LOG2 = 10,
    parameter int CNT_W    = WIN_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cg_valid,
    input  logic [4:0]       cg_data,
    input  logic             win_restart,
    input  logic [3:0]       cutoff_exp,
    input  logic [3:0]       alarm_exp,
    input  logic             fault_clr,
    output logic             rpt_valid,
    output logic [4:0]       rpt_data,
    output logic [CNT_W-1:0] err_count,
    output logic [3:0]       ber_exp,
    output logic             win_done,
    output logic             alarm,
    output logic             fault_req
);
    typedef struct packed {
        logic [WIN_LOG2-1:0] grp;
        logic [CNT_W-1:0]    run;
        logic [CNT_W-1:0]    cnt;
        logic [EXP_W-1:0]    bexp;
        logic                fault;
        logic                done;
        logic                rv;
        logic [CG_W-1:0]     rd;
    } state_t;

    localparam state_t RST_STATE = '{
        grp: '0, run: '0, cnt: '0, bexp: EXP_NONE,
        fault: 1'b0, done: 1'b0, rv: 1'b0, rd: '0
    };

    state_t           st_d, st_q;
    logic             viol;
    logic [CG_W-1:0]  cg_fix;
    logic [CNT_W-1:0] run_inc;
    logic [EXP_W-1:0] exp_new;

    lem_code_check chk_u (
        .cg_in  (cg_data),
        .viol   (viol),
        .cg_fix (cg_fix)
    );

    lem_ber_calc #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) ber_u (
        .count (run_inc),
        .exp_o (exp_new)
    );

    assign run_inc = st_q.run + CNT_W'(viol);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rv   = cg_valid;
        st_d.rd   = cg_fix;
        if (fault_clr) st_d.fault = 1'b0;
        if (win_restart) begin
            st_d.grp = '0;
            st_d.run = '0;
        end else if (cg_valid) begin
            if (st_q.grp == '1) begin
                st_d.grp  = '0;
                st_d.run  = '0;
                st_d.cnt  = run_inc;
                st_d.bexp = exp_new;
                st_d.done = 1'b1;
                if (exp_new < cutoff_exp) st_d.fault = 1'b1;
            end else begin
                st_d.grp = st_q.grp + 1'b1;
                st_d.run = run_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign rpt_valid = st_q.rv;
    assign rpt_data  = st_q.rd;
    assign err_count = st_q.cnt;
    assign ber_exp   = st_q.bexp;
    assign win_done  = st_q.done;
    assign fault_req = st_q.fault;
    assign alarm     = (st_q.bexp < alarm_exp);
endmodule

// File: rtl/lem_checker.sv
module lem_checker #(
    parameter int WIN_LOG2 = 10,
    parameter int CNT_W    = WIN_LOG2 + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cg_valid,
    input logic             fault_clr,
    input logic             rpt_valid,
    input logic [4:0]       rpt_data,
    input logic [CNT_W-1:0] err_count,
    input logic [3:0]       ber_exp,
    input logic             win_done,
    input logic             fault_req
);
    function automatic logic is_bad(input logic [4:0] g);
        return g inside {5'b00001, 5'b00010, 5'b00011, 5'b00101,
                         5'b00110, 5'b01000, 5'b01100, 5'b10000};
    endfunction

    AST_RPT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cg_valid |=> rpt_valid); // R2
    AST_RPT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> !is_bad(rpt_data)); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(err_count)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        err_count <= CNT_W'(2 ** WIN_LOG2)); // R3
    AST_EXP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && err_count == '0) |-> ber_exp == 4'd15); // R4
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req && !fault_clr) |=> fault_req); // R5
endmodule

bind link_err_mon lem_checker #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cg_valid  (cg_valid),
    .fault_clr (fault_clr),
    .rpt_valid (rpt_valid),
    .rpt_data  (rpt_data),
    .err_count (err_count),
    .ber_exp   (ber_exp),
    .win_done  (win_done),
    .fault_req (fault_req)
);

// File: tb/link_err_mon_tb_top.sv
module link_err_mon_tb_top;
    localparam int N    = 10;
    localparam int WIN  = 2 ** N;
    localparam int CW   = N + 1;
    localparam logic [4:0] ERR_CG = 5'b01100; // 10100 with bits 4:3 complemented

    localparam int NV = 9;
    localparam int VEC_ERR [NV] = '{0, 1, 9, 10, 99, 100, 999, 1000, 1024};
    localparam int VEC_EXP [NV] = '{15, 3, 3, 2, 2, 1, 1, 0, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cg_valid = 1'b0;
    logic [4:0]    cg_data = '0;
    logic          win_restart = 1'b0;
    logic [3:0]    cutoff_exp = 4'd2;
    logic [3:0]    alarm_exp = 4'd3;
    logic          fault_clr = 1'b0;
    logic          rpt_valid;
    logic [4:0]    rpt_data;
    logic [CW-1:0] err_count;
    logic [3:0]    ber_exp;
    logic          win_done;
    logic          alarm;
    logic          fault_req;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    link_err_mon #(.WIN_LOG2(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid), .cg_data(cg_data),
        .win_restart(win_restart), .cutoff_exp(cutoff_exp), .alarm_exp(alarm_exp),
        .fault_clr(fault_clr), .rpt_valid(rpt_valid), .rpt_data(rpt_data),
        .err_count(err_count), .ber_exp(ber_exp), .win_done(win_done),
        .alarm(alarm), .fault_req(fault_req)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic [4:0] d, input logic rs, input logic clr);
        @(negedge clk);
        cg_valid = v; cg_data = d; win_restart = rs; fault_clr = clr;
    endtask

    function automatic logic ref_bad(input logic [4:0] g);
        case (g)
            5'd1, 5'd2, 5'd3, 5'd5, 5'd6, 5'd8, 5'd12, 5'd16: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // legal filler alternates a data group and idle
    function automatic logic [4:0] filler(input int i);
        return (i % 2 == 1) ? 5'b10100 : 5'b11111;
    endfunction

    // full window: nerr leading errors; last group carries clr_last as fault_clr
    task automatic run_window(input int nerr, input logic clr_last);
        for (int i = 0; i < WIN; i++)
            send(1'b1, (i < nerr) ? ERR_CG : filler(i), 1'b0, (i == WIN - 1) ? clr_last : 1'b0);
        send(1'b0, 5'b00000, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 err_count", int'(err_count), 0);
        check("R9 ber_exp", int'(ber_exp), 15);
        check("R9 fault_req", int'(fault_req), 0);
        check("R9 win_done", int'(win_done), 0);
        check("R9 rpt_valid", int'(rpt_valid), 0);
        rst_n = 1'b1;

        // R1 / R2: every code value through the repeat path
        for (int c = 0; c < 32; c++) begin
            send(1'b1, 5'(c), 1'b0, 1'b0);
            send(1'b0, 5'b11111, 1'b0, 1'b0);
            check("R2 rpt_valid hi", int'(rpt_valid), 1);
            check("R1 R2 rpt_data", int'(rpt_data), ref_bad(5'(c)) ? 4 : c);
            send(1'b0, 5'b11111, 1'b0, 1'b0);
            check("R2 rpt_valid lo", int'(rpt_valid), 0);
        end
        // restart clears the partial window left by the loop above
        send(1'b0, 5'b11111, 1'b1, 1'b0);

        // vector table: count, exponent, alarm, fault
        for (int v = 0; v < NV; v++) begin
            run_window(VEC_ERR[v], 1'b0);
            check("R3 win_done", int'(win_done), 1);
            check("R3 err_count", int'(err_count), VEC_ERR[v]);
            check("R4 ber_exp", int'(ber_exp), VEC_EXP[v]);
            check("R7 alarm", int'(alarm), (VEC_EXP[v] < 3) ? 1 : 0);
            check("R5 fault_req", int'(fault_req), (VEC_EXP[v] < 2) ? 1 : 0);
            send(1'b0, 5'b11111, 1'b0, 1'b0);
            check("R3 win_done pulse", int'(win_done), 0);
            send(1'b0, 5'b11111, 1'b0, 1'b1);
            send(1'b0, 5'b11111, 1'b0, 1'b0);
            check("R6 fault cleared", int'(fault_req), 0);
        end

        // R5 sticky: bad window then clean window, fault stays
        run_window(500, 1'b0);
        check("R5 set", int'(fault_req), 1);
        run_window(0, 1'b0);
        check("R5 sticky", int'(fault_req), 1);
        check("R7 alarm clear", int'(alarm), 0);
        // R6 set wins over simultaneous clear
        run_window(200, 1'b1);
        check("R6 set wins", int'(fault_req), 1);
        send(1'b0, 5'b11111, 1'b0, 1'b1);
        send(1'b0, 5'b11111, 1'b0, 1'b0);
        check("R6 clear", int'(fault_req), 0);

        // R8 restart discards partial count; restart group still repeated
        for (int i = 0; i < 300; i++) send(1'b1, ERR_CG, 1'b0, 1'b0);
        send(1'b1, ERR_CG, 1'b1, 1'b0);
        send(1'b0, 5'b11111, 1'b0, 1'b0);
        check("R8 restart group repeated", int'(rpt_valid), 1);
        check("R8 restart no done", int'(win_done), 0);
        run_window(5, 1'b0);
        check("R8 count after restart", int'(err_count), 5);
        check("R8 exp after restart", int'(ber_exp), 3);

        // R3 invalid cycles carrying violations are ignored
        for (int i = 0; i < WIN; i++) begin
            if (i % 100 == 0) send(1'b0, ERR_CG, 1'b0, 1'b0);
            send(1'b1, (i < 20) ? ERR_CG : filler(i), 1'b0, 1'b0);
        end
        send(1'b0, 5'b00000, 1'b0, 1'b0);
        check("R3 gaps done", int'(win_done), 1);
        check("R3 gaps count", int'(err_count), 20);
        check("R4 gaps exp", int'(ber_exp), 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule